// File: doc/BRIEF.md
# Write-once code line encoder for phase-change memory

This block keeps a memory line of 2-bit data symbols, each stored as a 3-bit cell group. The coding follows a write-once scheme. After every cell of a group has been driven to 1 by a proactive preset, the next two writes of new data only ever clear bits (1 to 0). Clearing is the fast operation in a phase-change cell. Setting a bit (0 to 1) costs roughly eight read latencies. The preset itself is done ahead of the real write-back, so the write-back stays fast.

Each group carries a generation: fresh (all ones after reset or preset), first, or second. A write of new data moves a fresh group to a first-generation codeword and a first-generation group to a second-generation codeword. On a third write, a selectable mode either writes the first-generation codeword directly, which needs SETs, or spends one extra stall cycle presetting the affected groups and then writes the codeword.

The line streams through one chunk of symbols per clock with a valid/ready handshake. A read beat returns the decoded data and the raw cell codes of the current chunk. After the last chunk of a line, a done pulse reports how many bits were set and cleared during that line, together with a slow-write flag.

Top module: `wom_line_codec`

## Requirements
- R1: After reset every group holds 111 in generation fresh and reads back as data 00. `in_ready` is 1 while `in_valid` is 0, and `line_done`, `rd_valid`, `line_set_cnt`, `line_reset_cnt` and `line_slow` are 0.
- R2: A write (`in_op`=0) of data that differs from the stored value moves a fresh group to its first codeword: 00→111, 01→110, 10→101, 11→011. When every group was fresh, the line counts no SETs.
- R3: A write of differing data to a first-generation group stores the second codeword: 00→000, 01→001, 10→010, 11→100. Every such change clears bits only.
- R4: A write of data equal to the decoded stored value leaves the cells and the generation unchanged and adds no transitions.
- R5: With `third_mode`=0, a write of differing data to a second-generation group stores the first codeword in the same cycle and moves the group to generation first, counting the SETs this needs.
- R6: With `third_mode`=1, a write beat that meets a second-generation group with differing data holds `in_ready` low for exactly one cycle. In that cycle those groups go to 111 in generation fresh. The held beat is then accepted as a normal write, and the transitions of both cycles count toward the line.
- R7: A preset beat (`in_op`=1) drives every group of the chunk to 111 in generation fresh. It counts only SETs.
- R8: A read beat (`in_op`=2 or 3) is answered on the following cycle with `rd_valid`=1. `rd_data` holds the decoded symbols: a code of weight two or more decodes by the first table, and any other code by the second table. `rd_cells` holds the raw codes. A read changes no cell.
- R9: `line_done` pulses for one cycle after the last chunk of a line is accepted. At the same time `line_set_cnt` and `line_reset_cnt` give the total 0→1 and 1→0 cell bit changes of that line, and `line_slow` is 1 exactly when the SET count is not zero.
- R10: Accepted beats walk the chunks in order from 0 and wrap after the last chunk. Chunk k holds symbols k·G to k·G+G−1, where G = CHUNK_BITS/2. Symbol j of a beat sits in data bits [2j+1:2j] and in `rd_cells` bits [3j+2:3j].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat offered |
| in_ready | output | 1 | Beat accepted this cycle; low during a preset stall |
| in_op | input | 2 | 0 write, 1 preset, 2 or 3 read |
| third_mode | input | 1 | 0 direct third write, 1 preset-then-write |
| in_data | input | CHUNK_BITS | Chunk data, 2 bits per symbol |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | CHUNK_BITS | Decoded chunk |
| rd_cells | output | 3*CHUNK_BITS/2 | Raw cell codes of the chunk |
| line_done | output | 1 | One-cycle pulse after the last chunk |
| line_set_cnt | output | CNTW | SET transitions of the finished line |
| line_reset_cnt | output | CNTW | RESET transitions of the finished line |
| line_slow | output | 1 | The finished line needed at least one SET |

## Verification
The hardest state to reach is a third write in preset mode. A chunk must hold groups that are already second-generation, and the new data must differ from the stored data in some of those groups but not in all chunks, so that stalls occur only in some chunks. The bench gets there with a small line of 64 symbols. It writes three patterns in a row and assigns each symbol a distinct triple of first, second and third data, which covers all 64 transition paths, including a third write whose data matches the preset value. The stall count, the totals and the read-back are each compared with an arithmetic model.

// File: rtl/wom_pkg.sv
package wom_pkg;

  typedef enum logic [1:0] {
    GEN_FRESH  = 2'd0,
    GEN_FIRST  = 2'd1,
    GEN_SECOND = 2'd2
  } gen_e;

  localparam logic [1:0] OP_WRITE  = 2'd0;
  localparam logic [1:0] OP_PRESET = 2'd1;
  localparam logic [2:0] ALL_ONES  = 3'b111;

  function automatic logic [2:0] code_gen1(input logic [1:0] d);
    case (d)
      2'd0:    return 3'b111;
      2'd1:    return 3'b110;
      2'd2:    return 3'b101;
      default: return 3'b011;
    endcase
  endfunction

  // second-generation code is the bitwise complement of the first
  function automatic logic [2:0] code_gen2(input logic [1:0] d);
    return ~code_gen1(d);
  endfunction

  function automatic logic [1:0] code_decode(input logic [2:0] c);
    logic [1:0] w;
    w = {1'b0, c[0]} + {1'b0, c[1]} + {1'b0, c[2]};
    if (w >= 2'd2) begin
      case (c)
        3'b111:  return 2'd0;
        3'b110:  return 2'd1;
        3'b101:  return 2'd2;
        default: return 2'd3;
      endcase
    end else begin
      case (c)
        3'b000:  return 2'd0;
        3'b001:  return 2'd1;
        3'b010:  return 2'd2;
        default: return 2'd3;
      endcase
    end
  endfunction

endpackage

// File: rtl/wom_group_code.sv
// Coding slice for one 3-bit cell group: decode, differ test, normal next code.
module wom_group_code
  import wom_pkg::*;
(
  input  logic [2:0] cell_q,
  input  gen_e       gen_q,
  input  logic [1:0] data,
  input  logic       do_write,
  input  logic       do_preset,
  input  logic       mode_preset,
  output logic       need_preset,
  output logic [1:0] dec,
  output logic [2:0] cell_d,
  output gen_e       gen_d
);

  logic differs;

  always_comb begin
    dec         = code_decode(cell_q);
    differs     = (dec != data);
    need_preset = do_write & mode_preset & (gen_q == GEN_SECOND) & differs;
    cell_d      = cell_q;
    gen_d       = gen_q;
    if (do_preset) begin
      cell_d = ALL_ONES;
      gen_d  = GEN_FRESH;
    end else if (do_write && differs) begin
      unique case (gen_q)
        GEN_FIRST: begin
          cell_d = code_gen2(data);
          gen_d  = GEN_SECOND;
        end
        default: begin
          cell_d = code_gen1(data);
          gen_d  = GEN_FIRST;
        end
      endcase
    end
  end

endmodule

// File: rtl/wom_line_acc.sv
// Chunk walker and per-line transition totals.
module wom_line_acc #(
  parameter  int NCHUNK = 32,
  parameter  int CCW    = 6,
  parameter  int CNTW   = 11,
  localparam int IDXW   = (NCHUNK > 1) ? $clog2(NCHUNK) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            beat_acc,
  input  logic            upd,
  input  logic [CCW-1:0]  ch_set,
  input  logic [CCW-1:0]  ch_clr,
  output logic [IDXW-1:0] idx,
  output logic            done,
  output logic [CNTW-1:0] tot_set,
  output logic [CNTW-1:0] tot_clr,
  output logic            slow
);

  logic [IDXW-1:0] idx_d;
  logic [CNTW-1:0] acc_set, acc_clr, sum_set, sum_clr, acc_set_d, acc_clr_d;
  logic            last, done_d;

  always_comb begin
    last      = (idx == IDXW'(NCHUNK - 1));
    done_d    = beat_acc & last;
    idx_d     = beat_acc ? (last ? '0 : idx + 1'b1) : idx;
    sum_set   = acc_set + (upd ? CNTW'(ch_set) : '0);
    sum_clr   = acc_clr + (upd ? CNTW'(ch_clr) : '0);
    acc_set_d = done_d ? '0 : sum_set;
    acc_clr_d = done_d ? '0 : sum_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= '0;
      acc_set <= '0;
      acc_clr <= '0;
      done    <= 1'b0;
      tot_set <= '0;
      tot_clr <= '0;
      slow    <= 1'b0;
    end else begin
      idx     <= idx_d;
      acc_set <= acc_set_d;
      acc_clr <= acc_clr_d;
      done    <= done_d;
      if (done_d) begin
        tot_set <= sum_set;
        tot_clr <= sum_clr;
        slow    <= (sum_set != '0);
      end
    end
  end

endmodule

// File: rtl/wom_line_codec.sv
// Line of write-once coded 3-bit groups; one chunk per beat.
// CHUNK_BITS/2 and LINE_BITS/CHUNK_BITS must be powers of two, each at least 2.
module wom_line_codec
  import wom_pkg::*;
#(
  parameter  int LINE_BITS  = 1024,
  parameter  int CHUNK_BITS = 32,
  localparam int GPC        = CHUNK_BITS / 2,
  localparam int CNTW       = $clog2(3 * (LINE_BITS / 2) + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [1:0]            in_op,
  input  logic                  third_mode,
  input  logic [CHUNK_BITS-1:0] in_data,
  output logic                  rd_valid,
  output logic [CHUNK_BITS-1:0] rd_data,
  output logic [3*GPC-1:0]      rd_cells,
  output logic                  line_done,
  output logic [CNTW-1:0]       line_set_cnt,
  output logic [CNTW-1:0]       line_reset_cnt,
  output logic                  line_slow
);

  localparam int SYMS   = LINE_BITS / 2;
  localparam int NCHUNK = LINE_BITS / CHUNK_BITS;
  localparam int IDXW   = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;
  localparam int JW     = $clog2(GPC);
  localparam int CCW    = $clog2(3 * GPC + 1);

  logic [2:0] cells_q [SYMS];
  gen_e       gen_q   [SYMS];

  logic [IDXW-1:0]       idx;
  logic                  wr_en, pre_en, upd, stall, beat_acc, rd_valid_d;
  logic [GPC-1:0]        need;
  logic [2:0]            nx_cell [GPC];
  gen_e                  nx_gen  [GPC];
  logic [1:0]            set_n   [GPC];
  logic [1:0]            clr_n   [GPC];
  logic [CCW-1:0]        ch_set, ch_clr;
  logic [CHUNK_BITS-1:0] rd_mux_data;
  logic [3*GPC-1:0]      rd_mux_cells;

  assign wr_en      = in_valid & (in_op == OP_WRITE);
  assign pre_en     = in_valid & (in_op == OP_PRESET);
  assign upd        = in_valid & ~in_op[1];
  assign stall      = |need;
  assign in_ready   = ~stall;
  assign beat_acc   = in_valid & ~stall;
  assign rd_valid_d = beat_acc & in_op[1];

  for (genvar j = 0; j < GPC; j++) begin : g_grp
    localparam logic [JW-1:0] JSEL = JW'(j);
    logic [2:0] cur_cell, enc_cell;
    gen_e       cur_gen, enc_gen;
    logic [1:0] dec;

    assign cur_cell = cells_q[{idx, JSEL}];
    assign cur_gen  = gen_q[{idx, JSEL}];

    wom_group_code u_code (
      .cell_q      (cur_cell),
      .gen_q       (cur_gen),
      .data        (in_data[2*j +: 2]),
      .do_write    (wr_en),
      .do_preset   (pre_en),
      .mode_preset (third_mode),
      .need_preset (need[j]),
      .dec         (dec),
      .cell_d      (enc_cell),
      .gen_d       (enc_gen)
    );

    // stall cycle: only groups needing a preset move, to all ones
    always_comb begin
      if (stall) begin
        nx_cell[j] = need[j] ? ALL_ONES  : cur_cell;
        nx_gen[j]  = need[j] ? GEN_FRESH : cur_gen;
      end else begin
        nx_cell[j] = enc_cell;
        nx_gen[j]  = enc_gen;
      end
      set_n[j] = 2'($countones(~cur_cell & nx_cell[j]));
      clr_n[j] = 2'($countones(cur_cell & ~nx_cell[j]));
    end

    assign rd_mux_data[2*j +: 2]  = dec;
    assign rd_mux_cells[3*j +: 3] = cur_cell;
  end

  always_comb begin
    ch_set = '0;
    ch_clr = '0;
    for (int j = 0; j < GPC; j++) begin
      ch_set = ch_set + CCW'(set_n[j]);
      ch_clr = ch_clr + CCW'(clr_n[j]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYMS; s++) begin
        cells_q[s] <= ALL_ONES;
        gen_q[s]   <= GEN_FRESH;
      end
    end else if (upd) begin
      for (int j = 0; j < GPC; j++) begin
        cells_q[{idx, JW'(j)}] <= nx_cell[j];
        gen_q[{idx, JW'(j)}]   <= nx_gen[j];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_cells <= '0;
    end else begin
      rd_valid <= rd_valid_d;
      if (rd_valid_d) begin
        rd_data  <= rd_mux_data;
        rd_cells <= rd_mux_cells;
      end
    end
  end

  wom_line_acc #(
    .NCHUNK (NCHUNK),
    .CCW    (CCW),
    .CNTW   (CNTW)
  ) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat_acc (beat_acc),
    .upd      (upd),
    .ch_set   (ch_set),
    .ch_clr   (ch_clr),
    .idx      (idx),
    .done     (line_done),
    .tot_set  (line_set_cnt),
    .tot_clr  (line_reset_cnt),
    .slow     (line_slow)
  );

endmodule

// File: rtl/wom_line_codec_chk.sv
module wom_line_codec_chk
  import wom_pkg::*;
#(
  parameter  int LINE_BITS  = 1024,
  parameter  int CHUNK_BITS = 32,
  localparam int SYMS       = LINE_BITS / 2,
  localparam int CNTW       = $clog2(3 * (LINE_BITS / 2) + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [1:0]      in_op,
  input logic            third_mode,
  input logic            rd_valid,
  input logic            line_done,
  input logic [CNTW-1:0] line_set_cnt,
  input logic            line_slow,
  input logic [2:0]      cells_q [SYMS],
  input gen_e            gen_q   [SYMS]
);

  for (genvar s = 0; s < SYMS; s++) begin : g_sym
    // R7: fresh groups always hold all ones
    a_r7_fresh_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_q[s] == GEN_FRESH) |-> (cells_q[s] == 3'b111))
      else $error("fresh group not all ones");
    // R2: first-generation codes carry two or more ones
    a_r2_first_heavy: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_q[s] == GEN_FIRST) |-> ($countones(cells_q[s]) >= 2))
      else $error("first generation code too light");
    // R3: second-generation codes carry at most one one
    a_r3_second_light: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_q[s] == GEN_SECOND) |-> ($countones(cells_q[s]) <= 1))
      else $error("second generation code too heavy");
  end

  // R6: a stall only comes from a write in preset-then-write mode
  a_r6_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> (in_op == 2'd0 && third_mode))
    else $error("stall without preset-mode write");

  // R6: a held beat is accepted right after its stall cycle
  a_r6_stall_once: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) ##1 in_valid |-> in_ready)
    else $error("stall longer than one cycle");

  // R8: every accepted read beat is answered next cycle
  a_r8_read_answer: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op[1]) |=> rd_valid)
    else $error("read beat not answered");

  // R9: done only follows an accepted beat
  a_r9_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> $past(in_valid && in_ready))
    else $error("done without accepted beat");

  // R9: slow flag agrees with the SET total
  a_r9_slow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> (line_slow == (line_set_cnt != '0)))
    else $error("slow flag disagrees with SET count");

endmodule

bind wom_line_codec wom_line_codec_chk #(
  .LINE_BITS  (LINE_BITS),
  .CHUNK_BITS (CHUNK_BITS)
) u_chk (.*);

// File: tb/wom_line_codec_bench.sv
module wom_line_codec_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LB    = 128;
  localparam int CB    = 16;
  localparam int NSYM  = LB / 2;
  localparam int G     = CB / 2;
  localparam int NCH   = LB / CB;
  localparam int CW    = $clog2(3 * NSYM + 1);
  localparam int LIMIT = 20000;

  logic          clk, rst_n, in_valid, in_ready, third_mode;
  logic [1:0]    in_op;
  logic [CB-1:0] in_data, rd_data;
  logic [3*G-1:0] rd_cells;
  logic          rd_valid, line_done, line_slow;
  logic [CW-1:0] line_set_cnt, line_reset_cnt;

  int n_chk = 0;
  int n_bad = 0;
  int m_cell [NSYM];
  int m_gen  [NSYM];

  wom_line_codec #(.LINE_BITS(LB), .CHUNK_BITS(CB)) u_wom_line_codec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .third_mode(third_mode), .in_data(in_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_cells(rd_cells),
    .line_done(line_done), .line_set_cnt(line_set_cnt),
    .line_reset_cnt(line_reset_cnt), .line_slow(line_slow)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // arithmetic reference codes
  function automatic int f2(input int d);
    return (d == 0) ? 0 : (1 << (d - 1));
  endfunction
  function automatic int f1(input int d);
    return 7 ^ f2(d);
  endfunction
  function automatic int pc(input int v);
    return ((v >> 0) & 1) + ((v >> 1) & 1) + ((v >> 2) & 1);
  endfunction
  function automatic int mdec(input int c);
    int b;
    b = (pc(c) >= 2) ? (7 ^ c) : c;
    return (b == 0) ? 0 : (b == 1) ? 1 : (b == 2) ? 2 : 3;
  endfunction
  function automatic logic [LB-1:0] mk(input int t);
    logic [LB-1:0] v;
    for (int s = 0; s < NSYM; s++) begin
      case (t)
        0:       v[2*s +: 2] = 2'(s & 3);
        1:       v[2*s +: 2] = 2'((s >> 2) & 3);
        2:       v[2*s +: 2] = 2'((s >> 4) & 3);
        default: v[2*s +: 2] = 2'((s ^ (s >> 3)) & 3);
      endcase
    end
    return v;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [1:0] op, input logic [CB-1:0] d, input bit mode,
                      inout int stalls);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_data = d; third_mode = mode;
    #1;
    while (!in_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic finish_line(input string req, input int st, input int est,
                             input int es, input int ec);
    chk({req, " R6 stall cycles"}, 64'(st), 64'(est));
    chk({req, " R9 done pulse"}, 64'(line_done), 64'd1);
    chk({req, " R9 set total"}, 64'(line_set_cnt), 64'(es));
    chk({req, " R9 reset total"}, 64'(line_reset_cnt), 64'(ec));
    chk({req, " R9 slow flag"}, 64'(line_slow), 64'(es != 0));
  endtask

  task automatic write_line(input logic [LB-1:0] v, input bit mode, input string req);
    int es, ec, est, st, d, old, nc;
    bit cst [NCH];
    es = 0; ec = 0; est = 0; st = 0;
    for (int k = 0; k < NCH; k++) cst[k] = 1'b0;
    for (int s = 0; s < NSYM; s++) begin
      old = m_cell[s];
      d   = int'(v[2*s +: 2]);
      if (mdec(old) != d) begin
        if (m_gen[s] == 2 && mode) begin
          es += pc(7 & ~old);
          ec += pc(7 & ~f1(d));
          m_cell[s] = f1(d);
          m_gen[s]  = (d == 0) ? 0 : 1;
          cst[s / G] = 1'b1;
        end else begin
          nc = (m_gen[s] == 1) ? f2(d) : f1(d);
          es += pc(~old & nc & 7);
          ec += pc(old & ~nc & 7);
          m_cell[s] = nc;
          m_gen[s]  = (m_gen[s] == 1) ? 2 : 1;
        end
      end
    end
    for (int k = 0; k < NCH; k++) if (cst[k]) est++;
    for (int k = 0; k < NCH; k++) begin
      beat(2'd0, v[CB*k +: CB], mode, st);
      if (k == 0) chk({req, " R9 no done mid-line"}, 64'(line_done), 64'd0);
    end
    finish_line(req, st, est, es, ec);
  endtask

  task automatic preset_line(input string req);
    int es, st;
    es = 0; st = 0;
    for (int s = 0; s < NSYM; s++) begin
      es += pc(7 & ~m_cell[s]);
      m_cell[s] = 7;
      m_gen[s]  = 0;
    end
    for (int k = 0; k < NCH; k++) beat(2'd1, '0, 1'b0, st);
    finish_line(req, st, 0, es, 0);
  endtask

  task automatic read_line(input string req);
    logic [CB-1:0]  ed;
    logic [3*G-1:0] ecl;
    int st;
    st = 0;
    for (int k = 0; k < NCH; k++) begin
      for (int j = 0; j < G; j++) begin
        ed[2*j +: 2]  = 2'(mdec(m_cell[k*G + j]));
        ecl[3*j +: 3] = 3'(m_cell[k*G + j]);
      end
      beat(2'd2 + 2'(k & 1), '0, 1'b0, st);
      chk({req, " R8 rd_valid"}, 64'(rd_valid), 64'd1);
      chk({req, " R8 R10 decoded chunk"}, 64'(rd_data), 64'(ed));
      chk({req, " R10 raw cells"}, 64'(rd_cells), 64'(ecl));
    end
    chk({req, " R9 read line done"}, 64'(line_done), 64'd1);
    chk({req, " R8 read adds no set"}, 64'(line_set_cnt), 64'd0);
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=<%0d cycles", LIMIT, LIMIT);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_op = 2'd0; in_data = '0; third_mode = 1'b0;
    for (int s = 0; s < NSYM; s++) begin
      m_cell[s] = 7;
      m_gen[s]  = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 in_ready", 64'(in_ready), 64'd1);
    chk("R1 line_done", 64'(line_done), 64'd0);
    chk("R1 rd_valid", 64'(rd_valid), 64'd0);
    chk("R1 set count", 64'(line_set_cnt), 64'd0);
    chk("R1 reset count", 64'(line_reset_cnt), 64'd0);
    chk("R1 slow", 64'(line_slow), 64'd0);
    read_line("R1");

    // R2 first write from fresh: RESET only
    write_line(mk(0), 1'b0, "R2");
    chk("R2 no SET on first write", 64'(line_set_cnt), 64'd0);
    read_line("R2");

    // R3 second write: RESET only
    write_line(mk(1), 1'b0, "R3");
    chk("R3 no SET on second write", 64'(line_set_cnt), 64'd0);
    read_line("R3");

    // R4 same data again
    write_line(mk(1), 1'b0, "R4");
    chk("R4 no SET", 64'(line_set_cnt), 64'd0);
    chk("R4 no RESET", 64'(line_reset_cnt), 64'd0);
    read_line("R4");

    // R5 direct third write
    write_line(mk(2), 1'b0, "R5");
    read_line("R5");

    // R7 preset
    preset_line("R7");
    chk("R7 preset no RESET", 64'(line_reset_cnt), 64'd0);
    read_line("R7");

    // R6 preset-then-write third write
    write_line(mk(0), 1'b1, "R6 w1");
    write_line(mk(1), 1'b1, "R6 w2");
    write_line(mk(2), 1'b1, "R6 w3");
    read_line("R6");
    write_line(mk(3), 1'b1, "R6 w4");
    read_line("R6 mixed");

    // mixed direct mode over mixed generations
    write_line(mk(0), 1'b0, "R5 mixed");
    write_line(mk(3), 1'b0, "R5 mixed2");
    read_line("R5 mixed");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule